// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block sits next to a memory port and observes every request that passes through it. Each request carries a context number, a byte address, a write flag and a locked flag. A locked read is a load-reserved access, and it records a reservation for its context. A locked write is a store-conditional access. A write without the locked flag is a plain store. For every write the block answers, in the same cycle, whether memory may be written. For a conditional write it also returns a status word.

Addresses are masked down to a reservation granule of `2**GRAN_LSB` bytes before they are stored or compared. The table holds one slot per context, so a context owns at most one reservation, and a new load-reserved simply replaces the old one. Any write to a reserved granule removes every reservation on that granule, whichever context owns it. This holds whether the write is a plain store, a conditional store that succeeds or a conditional store that fails.

Top module: `lrsc_monitor`

## Requirements
- R1: After reset no context holds a reservation, so a conditional store issued before any load-reserved fails.
- R2: A conditional store from context c to granule g succeeds when c holds a reservation on g. It then drives permit_o=1 and sc_status_o=1 in the same cycle as the request.
- R3: A load-reserved from a context that already holds a reservation replaces it. Afterwards the old granule no longer counts for that context and the new one does.
- R4: Address bits below GRAN_LSB are ignored. Addresses that differ only in those bits match, and addresses in different granules do not.
- R5: A plain store (write=1, locked=0) always drives permit_o=1 and sc_status_o=0.
- R6: A plain store removes every reservation on its granule, for all contexts.
- R7: A successful conditional store removes the reservations that other contexts hold on the same granule.
- R8: A conditional store fails (permit_o=0, sc_status_o=0) when its context has no reservation on that granule, even if another context has one. The failed store still removes every reservation on that granule.
- R9: A read with locked=0 leaves all reservations unchanged.
- R10: A write to a different granule leaves a reservation intact.
- R11: When no write is presented (idle or any read), permit_o=0 and sc_status_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | A request is present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_locked_i | input | 1 | Locked flag: load-reserved on a read, store-conditional on a write |
| req_ctx_i | input | CTX_W | Requesting context number |
| req_addr_i | input | ADDR_W | Byte address |
| permit_o | output | 1 | Memory may be written by this request (combinational) |
| sc_status_o | output | STATUS_W | Conditional store result: 1 success, 0 failure; 0 for other requests |

## Verification
The assertions check four rules on every clocked cycle:
- plain stores are always permitted;
- a conditional store's permit and status agree;
- a nonzero status appears only on a conditional store;
- the outputs stay quiet on reads and idle cycles.

They also check that a conditional store which directly follows any write to the same granule fails.

Some behaviour depends on history over many cycles: replacement of a context's reservation, survival across plain reads and unrelated writes, removal of other contexts' reservations, and the state after reset. Only the bench scenarios, run against the behavioural reference model, can show these.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_READ,
    OP_RSV,
    OP_STORE,
    OP_COND
  } op_e;
endpackage

// File: rtl/lrsc_decode.sv
module lrsc_decode
  import lrsc_pkg::*;
(
  input  logic valid_i,
  input  logic write_i,
  input  logic locked_i,
  output op_e  op_o
);
  always_comb begin
    if (!valid_i)     op_o = OP_IDLE;
    else if (write_i) op_o = locked_i ? OP_COND : OP_STORE;
    else              op_o = locked_i ? OP_RSV : OP_READ;
  end
endmodule

// File: rtl/lrsc_slot.sv
module lrsc_slot
  import lrsc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int CTX_W   = 3,
  parameter int SLOT_ID = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  op_e               op_i,
  input  logic [CTX_W-1:0]  ctx_i,
  input  logic [ADDR_W-1:0] gran_i,
  output logic              hit_o
);
  localparam logic [CTX_W-1:0] MY_ID = CTX_W'(SLOT_ID);

  logic              vld_q;
  logic [ADDR_W-1:0] gran_q;
  logic              own;
  logic              is_write;

  assign own      = (ctx_i == MY_ID);
  assign hit_o    = vld_q && (gran_q == gran_i);
  assign is_write = (op_i == OP_STORE) || (op_i == OP_COND);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      gran_q <= '0;
    end else if (op_i == OP_RSV && own) begin
      vld_q  <= 1'b1;
      gran_q <= gran_i;
    end else if (is_write && hit_o) begin
      vld_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/lrsc_verdict.sv
module lrsc_verdict
  import lrsc_pkg::*;
#(
  parameter int NUM_CTX  = 8,
  parameter int CTX_W    = 3,
  parameter int STATUS_W = 32
) (
  input  op_e                 op_i,
  input  logic [CTX_W-1:0]    ctx_i,
  input  logic [NUM_CTX-1:0]  hit_i,
  output logic                permit_o,
  output logic [STATUS_W-1:0] status_o
);
  logic own_hit;

  always_comb begin
    own_hit = 1'b0;
    for (int i = 0; i < NUM_CTX; i++) begin
      if (ctx_i == CTX_W'(i)) own_hit = hit_i[i];
    end
  end

  always_comb begin
    permit_o = 1'b0;
    status_o = '0;
    case (op_i)
      OP_STORE: permit_o = 1'b1;
      OP_COND: begin
        permit_o = own_hit;
        status_o = STATUS_W'(own_hit);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
  import lrsc_pkg::*;
#(
  parameter int NUM_CTX  = 8,
  parameter int ADDR_W   = 32,
  parameter int GRAN_LSB = 3,
  parameter int STATUS_W = 32,
  localparam int CTX_W   = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic                req_write_i,
  input  logic                req_locked_i,
  input  logic [CTX_W-1:0]    req_ctx_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  output logic                permit_o,
  output logic [STATUS_W-1:0] sc_status_o
);
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((64'd1 << GRAN_LSB) - 64'd1);

  op_e                op;
  logic [ADDR_W-1:0]  gran;
  logic [NUM_CTX-1:0] hit;

  assign gran = req_addr_i & ~LOW_MASK;

  lrsc_decode i_decode (
    .valid_i  (req_valid_i),
    .write_i  (req_write_i),
    .locked_i (req_locked_i),
    .op_o     (op)
  );

  for (genvar g = 0; g < NUM_CTX; g++) begin : g_slot
    lrsc_slot #(
      .ADDR_W  (ADDR_W),
      .CTX_W   (CTX_W),
      .SLOT_ID (g)
    ) i_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .op_i   (op),
      .ctx_i  (req_ctx_i),
      .gran_i (gran),
      .hit_o  (hit[g])
    );
  end

  lrsc_verdict #(
    .NUM_CTX  (NUM_CTX),
    .CTX_W    (CTX_W),
    .STATUS_W (STATUS_W)
  ) i_verdict (
    .op_i     (op),
    .ctx_i    (req_ctx_i),
    .hit_i    (hit),
    .permit_o (permit_o),
    .status_o (sc_status_o)
  );
endmodule

// File: rtl/lrsc_checker.sv
module lrsc_checker #(
  parameter int ADDR_W   = 32,
  parameter int GRAN_LSB = 3,
  parameter int STATUS_W = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_valid_i,
  input logic                req_write_i,
  input logic                req_locked_i,
  input logic [ADDR_W-1:0]   req_addr_i,
  input logic                permit_o,
  input logic [STATUS_W-1:0] sc_status_o
);
  localparam logic [ADDR_W-1:0] LOW = ADDR_W'((64'd1 << GRAN_LSB) - 64'd1);

  logic is_wr, is_cond;
  assign is_wr   = req_valid_i && req_write_i;
  assign is_cond = is_wr && req_locked_i;

  assert_store_permit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_wr && !req_locked_i) |-> (permit_o && sc_status_o == '0));

  assert_cond_agree_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_cond |-> (sc_status_o == STATUS_W'(permit_o)));

  assert_status_only_cond_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_status_o != '0) |-> is_cond);

  assert_quiet_non_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_wr |-> (!permit_o && sc_status_o == '0));

  assert_write_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_cond && $past(is_wr) && ((req_addr_i & ~LOW) == ($past(req_addr_i) & ~LOW)))
      |-> (sc_status_o == '0));
endmodule

bind lrsc_monitor lrsc_checker #(
  .ADDR_W   (ADDR_W),
  .GRAN_LSB (GRAN_LSB),
  .STATUS_W (STATUS_W)
) i_lrsc_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_write_i  (req_write_i),
  .req_locked_i (req_locked_i),
  .req_addr_i   (req_addr_i),
  .permit_o     (permit_o),
  .sc_status_o  (sc_status_o)
);

// File: tb/test_lrsc_monitor.sv
module test_lrsc_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CTX    = 8;
  localparam int ADDR_W     = 32;
  localparam int GRAN_LSB   = 3;
  localparam int STATUS_W   = 32;
  localparam int CTX_W      = 3;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                valid = 1'b0, write = 1'b0, locked = 1'b0;
  logic [CTX_W-1:0]    ctx = '0;
  logic [ADDR_W-1:0]   addr = '0;
  logic                permit;
  logic [STATUS_W-1:0] status;

  int total = 0, bad = 0;

  // reference model state
  bit                m_vld [NUM_CTX];
  logic [ADDR_W-1:0] m_gran [NUM_CTX];

  always #(CLK_PERIOD/2) clk = ~clk;

  lrsc_monitor #(
    .NUM_CTX(NUM_CTX), .ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB), .STATUS_W(STATUS_W)
  ) i_lrsc_monitor (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_write_i(write),
    .req_locked_i(locked), .req_ctx_i(ctx), .req_addr_i(addr),
    .permit_o(permit), .sc_status_o(status)
  );

  function automatic logic [ADDR_W-1:0] granule(logic [ADDR_W-1:0] a);
    return a >> GRAN_LSB;
  endfunction

  task automatic compare(string tag, bit exp_p, int unsigned exp_s);
    total++;
    if (permit !== exp_p || status !== STATUS_W'(exp_s)) begin
      bad++;
      $display("FAIL %s: permit=%0b status=%0d expected permit=%0b status=%0d",
               tag, permit, status, exp_p, exp_s);
    end
  endtask

  task automatic do_req(bit w, bit l, int c, logic [ADDR_W-1:0] a, string tag);
    bit own_hit, exp_p;
    @(negedge clk);
    valid = 1'b1; write = w; locked = l; ctx = CTX_W'(c); addr = a;
    #(CLK_PERIOD/4);
    own_hit = m_vld[c] && (m_gran[c] == granule(a));
    exp_p   = w && (!l || own_hit);
    compare(tag, exp_p, (w && l && own_hit) ? 1 : 0);
    @(posedge clk);
    if (!w && l) begin
      m_vld[c]  = 1'b1;
      m_gran[c] = granule(a);
    end else if (w) begin
      foreach (m_vld[i])
        if (m_vld[i] && m_gran[i] == granule(a)) m_vld[i] = 1'b0;
    end
  endtask

  task automatic do_idle(string tag);
    @(negedge clk);
    valid = 1'b0; write = 1'b0; locked = 1'b0;
    #(CLK_PERIOD/4);
    compare(tag, 1'b0, 0);
    @(posedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    foreach (m_vld[i]) begin m_vld[i] = 1'b0; m_gran[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    do_idle("R11 reset idle");
    do_req(1, 1, 0, 32'h100, "R1 cond store after reset");

    do_req(0, 1, 1, 32'h200, "R11 reserve read quiet");
    do_req(1, 1, 1, 32'h200, "R2 cond store success");

    do_req(0, 1, 2, 32'h300, "R4 reserve");
    do_req(1, 1, 2, 32'h305, "R4 same granule offset");
    do_req(0, 1, 2, 32'h300, "R4 reserve again");
    do_req(1, 1, 2, 32'h308, "R4 next granule fails");

    do_req(0, 1, 3, 32'h400, "R3 first reserve");
    do_req(0, 1, 3, 32'h500, "R3 replace reserve");
    do_req(1, 1, 3, 32'h400, "R3 old granule fails");
    do_req(1, 1, 3, 32'h500, "R3 new granule succeeds");

    do_req(0, 1, 4, 32'h700, "R9 reserve");
    do_req(0, 0, 4, 32'h800, "R9 plain read own");
    do_req(0, 0, 5, 32'h700, "R9 plain read other");
    do_req(1, 1, 4, 32'h700, "R9 reservation kept");

    do_req(0, 1, 0, 32'h900, "R6 reserve c0");
    do_req(0, 1, 5, 32'h900, "R6 reserve c5");
    do_req(1, 0, 6, 32'h904, "R5 plain store permitted");
    do_req(1, 1, 0, 32'h900, "R6 c0 cleared");
    do_req(1, 1, 5, 32'h900, "R6 c5 cleared");

    do_req(0, 1, 0, 32'hA00, "R7 reserve c0");
    do_req(0, 1, 1, 32'hA00, "R7 reserve c1");
    do_req(1, 1, 0, 32'hA00, "R7 c0 succeeds");
    do_req(1, 1, 1, 32'hA00, "R7 c1 cleared");

    do_req(0, 1, 2, 32'hB00, "R8 reserve c2");
    do_req(1, 1, 3, 32'hB00, "R8 foreign cond fails");
    do_req(1, 1, 2, 32'hB00, "R8 failed cond cleared owner");

    do_req(0, 1, 6, 32'hC00, "R10 reserve");
    do_req(1, 0, 7, 32'hD00, "R10 unrelated store");
    do_req(1, 1, 6, 32'hC00, "R10 reservation kept");

    for (int n = 0; n < 600; n++) begin
      int unsigned r = $urandom;
      bit w = r[0], l = r[1];
      int c = int'(r[6:4]);
      logic [ADDR_W-1:0] a = {24'h0, 2'b0, r[10:9], 1'b0, r[13:11]} << 2;
      if (r[15:14] == 2'b00) do_idle("R11 random idle");
      else if (w && l)       do_req(w, l, c, a, "R8 random cond");
      else if (w)            do_req(w, l, c, a, "R5 random store");
      else if (l)            do_req(w, l, c, a, "R3 random reserve");
      else                   do_req(w, l, c, a, "R9 random read");
    end

    do_idle("R11 final idle");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule